// File: doc/BRIEF.md
# Successive-Approximation Converter Capture Sequencer

This block drives the active-low conversion-start pin of an external successive-approximation converter and follows the converter's active-low busy output. It captures the 14-bit two's complement result and the out-of-range flag, and it emits each result as one word on a valid/ready stream. Each word carries a range class and the index of the conversion that produced the result.

The converter publishes a result only a few nanoseconds after busy rises. For this reason the sequencer samples the data bus one cycle after it returns the start pin high, and that value belongs to the conversion before the one just launched. The block tracks this one-deep lag. It discards the first capture after enable or after a fault, because that word is stale. It tags every other word with the index of the conversion that completed before the current one.

Conversions run single-shot, one per request pulse, or free-running at a programmable period. An enable input from a power or range manager gates every new launch. The busy input passes through a synchronizer before the block looks for edges. A minimum acquisition window follows every conversion, and a programmable timeout guards against a converter that never finishes.

Top module: `adc_cap_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, the start pin is high, the stream valid is low and the error output is low.
- R2: A falling edge of the start pin happens only while enable is high. In free-run mode the block launches on its own. In single-shot mode it launches exactly once per request pulse. With enable low, no launch happens in either mode.
- R3: Each start pulse stays low for exactly START_W clock cycles and then returns high. With the defaults this is 2 cycles, which is 20 ns at 100 MHz.
- R4: The start pin never falls while the converter's busy output is low. A running conversion is never restarted.
- R5: Each emitted code equals the result of the conversion named by its index. The first capture after enable rises, or after a timeout, is discarded and not emitted.
- R6: Conversions are numbered from 0 after reset, one number per start pulse, with IDX_W-bit wrap. Emitted indices rise by one from word to word, except where a capture was discarded.
- R7: The range field encodes 0 for in range (flag low), 1 for over-range (flag high and code bit 13 low) and 2 for under-range (flag high and code bit 13 high).
- R8: In free-run mode, when the period input exceeds the natural conversion cycle, consecutive falling edges of the start pin are exactly the period input in clock cycles apart.
- R9: A word that is not accepted holds valid, code, range and index unchanged. No new conversion starts while a word is waiting.
- R10: If busy has not completed a low-to-high cycle within the timeout input in cycles after the start pulse ends, the error output pulses high for one cycle and the sequencer returns to idle.
- R11: At least ACQ_CYC clock cycles pass between a rising edge of busy and the next falling edge of the start pin. With the defaults this is 10 cycles, which is 100 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable for new conversions |
| free_run_i | input | 1 | 1: free-run at the period; 0: single-shot |
| shot_req_i | input | 1 | Single-shot request pulse |
| period_i | input | CNT_W | Free-run sample period in cycles |
| timeout_i | input | CNT_W | Busy-completion bound in cycles |
| conv_n_o | output | 1 | Active-low conversion start to the converter |
| busy_n_i | input | 1 | Converter busy, low during conversion (asynchronous) |
| adc_code_i | input | DATA_W | Parallel result bus from the converter |
| adc_otr_i | input | 1 | Out-of-range flag from the converter |
| s_valid_o | output | 1 | Stream word valid |
| s_ready_i | input | 1 | Stream word accepted |
| s_code_o | output | DATA_W | Captured two's complement code |
| s_range_o | output | 2 | Range class (0 in, 1 over, 2 under) |
| s_idx_o | output | IDX_W | Index of the conversion that produced the code |
| err_o | output | 1 | One-cycle pulse on busy timeout |

## Verification
The converter model gives every conversion a distinct code computed from its index, and it raises the out-of-range flag on a fixed subset of them. Every emitted word can therefore be matched to one conversion, and a word shifted by one in the lag shows up at once. Codes with bit 13 both clear and set appear under the flag, which separates the over-range class from the under-range class. The sequencer is run in single-shot mode, free-run at a long and at a minimal period, under held backpressure, with a converter that never answers, and across an enable toggle. Together these runs separate a correct period from a correct acquisition floor, and a proper discard from a shifted index.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

    localparam int DATA_W = 14;

    typedef enum logic [1:0] {
        RNG_IN    = 2'b00,
        RNG_OVER  = 2'b01,
        RNG_UNDER = 2'b10
    } rng_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PULSE,
        ST_CONV,
        ST_ACQ
    } seq_st_e;

    typedef struct packed {
        logic [DATA_W-1:0] code;
        logic              otr;
    } raw_s;

    function automatic rng_e classify(input logic otr, input logic msb);
        if (!otr)
            return RNG_IN;
        else if (msb)
            return RNG_UNDER;
        else
            return RNG_OVER;
    endfunction

endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic busy_n_i,
    output logic busy_s_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= busy_n_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[STAGES-1];
    end

    assign busy_s_o = chain[STAGES-1];
    assign rise_o   = chain[STAGES-1] & ~prev;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o); // R4
endmodule

// File: rtl/adc_cap_ctrl.sv
module adc_cap_ctrl import adc_cap_pkg::*; #(
    parameter int CNT_W   = 16,
    parameter int START_W = 2,
    parameter int ACQ_CYC = 10,
    parameter int IDX_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             free_run_i,
    input  logic             shot_req_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] timeout_i,
    input  logic             busy_s_i,
    input  logic             busy_rise_i,
    input  logic             out_full_i,
    output logic             conv_n_o,
    output logic             cap_stb_o,
    output logic [IDX_W-1:0] cap_idx_o,
    output logic             err_o
);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(START_W - 1);
    localparam logic [CNT_W-1:0] ACQ_LAST   = CNT_W'(ACQ_CYC - 1);

    seq_st_e          st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] per_cnt;
    logic             primed;
    logic             pend;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] next_idx;
    logic [IDX_W-1:0] done_idx;
    logic             per_ok;
    logic             launch;

    assign per_ok = ({1'b0, per_cnt} + (CNT_W+1)'(1)) >= {1'b0, period_i};
    assign launch = (st == ST_IDLE) && en_i && !out_full_i &&
                    (free_run_i ? per_ok : pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            per_cnt   <= '0;
            primed    <= 1'b0;
            pend      <= 1'b0;
            cur_idx   <= '0;
            next_idx  <= '0;
            done_idx  <= '0;
            conv_n_o  <= 1'b1;
            cap_stb_o <= 1'b0;
            cap_idx_o <= '0;
            err_o     <= 1'b0;
        end else begin
            cap_stb_o <= 1'b0;
            err_o     <= 1'b0;
            if (per_cnt != '1) per_cnt <= per_cnt + 1'b1;
            if (!en_i) begin
                primed <= 1'b0;
                pend   <= 1'b0;
            end else if (shot_req_i) begin
                pend <= 1'b1;
            end
            case (st)
                ST_IDLE: begin
                    if (launch) begin
                        st       <= ST_PULSE;
                        cnt      <= '0;
                        per_cnt  <= '0;
                        conv_n_o <= 1'b0;
                        cur_idx  <= next_idx;
                        next_idx <= next_idx + 1'b1;
                        pend     <= 1'b0;
                    end
                end
                ST_PULSE: begin
                    if (cnt == PULSE_LAST) begin
                        st       <= ST_CONV;
                        cnt      <= '0;
                        conv_n_o <= 1'b1;
                        if (primed && en_i) begin
                            cap_stb_o <= 1'b1;
                            cap_idx_o <= done_idx;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_CONV: begin
                    if (busy_rise_i) begin
                        st       <= ST_ACQ;
                        cnt      <= '0;
                        done_idx <= cur_idx;
                        primed   <= en_i;
                    end else if (cnt >= timeout_i) begin
                        st     <= ST_IDLE;
                        err_o  <= 1'b1;
                        primed <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt >= ACQ_LAST) st  <= ST_IDLE;
                    else                 cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    // checker counters: consecutive low cycles of the start pin, and
    // cycles since the synchronized busy rose (saturating)
    logic [CNT_W-1:0] low_run;
    logic [CNT_W-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run <= '0;
            hi_run  <= '1;
        end else begin
            low_run <= conv_n_o ? '0 : low_run + 1'b1;
            if (busy_rise_i)      hi_run <= '0;
            else if (hi_run != '1) hi_run <= hi_run + 1'b1;
        end
    end

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_n_o) |-> (low_run == CNT_W'(START_W))); // R3
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_n_o) |-> busy_s_i); // R4
    AST_ACQ_FLOOR: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_n_o) |-> (hi_run >= CNT_W'(ACQ_CYC))); // R11
    AST_LAUNCH_ENABLED: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_n_o) |-> $past(en_i)); // R2
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !err_o); // R10
endmodule

// File: rtl/adc_cap_out.sv
module adc_cap_out import adc_cap_pkg::*; #(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_stb_i,
    input  raw_s              raw_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] code_o,
    output rng_e              rng_o,
    output logic [IDX_W-1:0]  idx_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            code_o  <= '0;
            rng_o   <= RNG_IN;
            idx_o   <= '0;
        end else if (cap_stb_i) begin
            valid_o <= 1'b1;
            code_o  <= raw_i.code;
            rng_o   <= classify(raw_i.otr, raw_i.code[DATA_W-1]);
            idx_o   <= idx_i;
        end else if (ready_i) begin
            valid_o <= 1'b0;
        end
    end

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        cap_stb_i |-> !valid_o); // R9
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !ready_i) |=> (valid_o && $stable(code_o) && $stable(idx_o) && $stable(rng_o))); // R9
    AST_OVER_MSB: assert property (@(posedge clk) disable iff (rst)
        (valid_o && rng_o == RNG_OVER) |-> !code_o[DATA_W-1]); // R7
    AST_UNDER_MSB: assert property (@(posedge clk) disable iff (rst)
        (valid_o && rng_o == RNG_UNDER) |-> code_o[DATA_W-1]); // R7
endmodule

// File: rtl/adc_cap_seq.sv
module adc_cap_seq import adc_cap_pkg::*; #(
    parameter int CNT_W    = 16,
    parameter int START_W  = 2,
    parameter int ACQ_CYC  = 10,
    parameter int IDX_W    = 8,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              free_run_i,
    input  logic              shot_req_i,
    input  logic [CNT_W-1:0]  period_i,
    input  logic [CNT_W-1:0]  timeout_i,
    output logic              conv_n_o,
    input  logic              busy_n_i,
    input  logic [DATA_W-1:0] adc_code_i,
    input  logic              adc_otr_i,
    output logic              s_valid_o,
    input  logic              s_ready_i,
    output logic [DATA_W-1:0] s_code_o,
    output logic [1:0]        s_range_o,
    output logic [IDX_W-1:0]  s_idx_o,
    output logic              err_o
);
    logic             busy_s;
    logic             busy_rise;
    logic             cap_stb;
    logic [IDX_W-1:0] cap_idx;
    raw_s             raw;
    rng_e             rng;

    assign raw.code = adc_code_i;
    assign raw.otr  = adc_otr_i;

    adc_busy_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .busy_n_i (busy_n_i),
        .busy_s_o (busy_s),
        .rise_o   (busy_rise)
    );

    adc_cap_ctrl #(
        .CNT_W   (CNT_W),
        .START_W (START_W),
        .ACQ_CYC (ACQ_CYC),
        .IDX_W   (IDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .en_i        (en_i),
        .free_run_i  (free_run_i),
        .shot_req_i  (shot_req_i),
        .period_i    (period_i),
        .timeout_i   (timeout_i),
        .busy_s_i    (busy_s),
        .busy_rise_i (busy_rise),
        .out_full_i  (s_valid_o),
        .conv_n_o    (conv_n_o),
        .cap_stb_o   (cap_stb),
        .cap_idx_o   (cap_idx),
        .err_o       (err_o)
    );

    adc_cap_out #(.IDX_W(IDX_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .cap_stb_i (cap_stb),
        .raw_i     (raw),
        .idx_i     (cap_idx),
        .ready_i   (s_ready_i),
        .valid_o   (s_valid_o),
        .code_o    (s_code_o),
        .rng_o     (rng),
        .idx_o     (s_idx_o)
    );

    assign s_range_o = rng;
endmodule

// File: tb/adc_cap_seq_bench.sv
`timescale 1ns/1ps
module adc_cap_seq_bench;
    localparam int START_W = 2;
    localparam int ACQ_CYC = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0, free_run = 1'b0, req = 1'b0, ready = 1'b1;
    logic [15:0] period = 16'd80, tmo = 16'd60;
    logic        busy_n = 1'b1;
    logic [13:0] adc_d = '0;
    logic        adc_otr = 1'b0;
    logic        conv_n, valid, err;
    logic [13:0] code;
    logic [1:0]  rng;
    logic [7:0]  idx;

    int  n_cmp = 0, n_bad = 0;
    int  n_falls = 0, mk = 0, k_cur = 0;
    time fall_t = 0, last_fall_t = 0, rise_busy_t = 0;
    bit  have_fall = 0, have_rise = 0, alive = 1, done = 0;
    int  rx_n = 0, last_idx = 0, first_idx_exp = 0;
    bit  expect_first = 0;
    int  n_over = 0, n_under = 0, err_n = 0;

    adc_cap_seq u_adc_cap_seq (
        .clk(clk), .rst(rst), .en_i(en), .free_run_i(free_run), .shot_req_i(req),
        .period_i(period), .timeout_i(tmo), .conv_n_o(conv_n), .busy_n_i(busy_n),
        .adc_code_i(adc_d), .adc_otr_i(adc_otr), .s_valid_o(valid), .s_ready_i(ready),
        .s_code_o(code), .s_range_o(rng), .s_idx_o(idx), .err_o(err)
    );

    always #5 clk = ~clk;

    function automatic logic [13:0] mdata(int k);
        return 14'(k * 1237 + 5);
    endfunction
    function automatic logic motr(int k);
        return (k % 5) == 3;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // converter model
    always @(negedge conv_n) begin
        k_cur = mk;
        mk++;
        if (alive) begin
            #15 busy_n = 1'b0;
            #260 busy_n = 1'b1;
            rise_busy_t = $time;
            have_rise = 1;
            #7;
            adc_d = mdata(k_cur);
            adc_otr = motr(k_cur);
        end
    end

    // start-pin monitors
    always @(negedge conv_n) begin
        chk(busy_n === 1'b1, "R4 start while busy", int'(busy_n), 1);
        if (have_rise)
            chk(($time - rise_busy_t) >= ACQ_CYC * 10, "R11 acquisition ns",
                int'($time - rise_busy_t), ACQ_CYC * 10);
        last_fall_t = fall_t;
        fall_t = $time;
        have_fall = 1;
        n_falls++;
    end
    always @(posedge conv_n) begin
        if (have_fall)
            chk(($time - fall_t) == START_W * 10, "R3 pulse ns", int'($time - fall_t), START_W * 10);
    end

    // stream monitor
    always @(negedge clk) begin
        if (!rst && valid && ready) begin
            int er;
            er = motr(idx) ? (mdata(idx)[13] ? 2 : 1) : 0;
            chk(code == mdata(idx), "R5 code", int'(code), int'(mdata(idx)));
            chk(int'(rng) == er, "R7 range", int'(rng), er);
            if (expect_first) begin
                chk(int'(idx) == first_idx_exp, "R5 first index", int'(idx), first_idx_exp);
                expect_first = 0;
            end else begin
                chk(int'(idx) == ((last_idx + 1) % 256), "R6 index step", int'(idx), (last_idx + 1) % 256);
            end
            if (rng == 2'd1) n_over++;
            if (rng == 2'd2) n_under++;
            last_idx = idx;
            rx_n++;
        end
        if (!rst && err) err_n++;
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req();
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cyc(5);
        chk(conv_n === 1'b1, "R1 start pin", int'(conv_n), 1);
        chk(valid === 1'b0, "R1 valid", int'(valid), 0);
        chk(err === 1'b0, "R1 error", int'(err), 0);
        rst = 1'b0;
        cyc(1);
        chk(conv_n === 1'b1 && valid === 1'b0, "R1 after release", int'(conv_n), 1);
    endtask

    task automatic t_disabled();
        free_run = 1'b1; period = 16'd80;
        cyc(200);
        chk(n_falls == 0, "R2 disabled launches", n_falls, 0);
        free_run = 1'b0;
        pulse_req();
        cyc(50);
        chk(n_falls == 0, "R2 request while disabled", n_falls, 0);
    endtask

    task automatic t_single();
        en = 1'b1;
        expect_first = 1; first_idx_exp = 0;
        pulse_req();
        cyc(100);
        chk(n_falls == 1, "R2 one shot", n_falls, 1);
        chk(rx_n == 0, "R5 first capture discarded", rx_n, 0);
        pulse_req();
        cyc(100);
        chk(n_falls == 2, "R2 second shot", n_falls, 2);
        chk(rx_n == 1, "R5 lagged word out", rx_n, 1);
        chk(last_idx == 0, "R6 first index", last_idx, 0);
        cyc(100);
        chk(n_falls == 2, "R2 no extra launch", n_falls, 2);
    endtask

    task automatic t_period();
        period = 16'd80; free_run = 1'b1;
        @(negedge conv_n);
        for (int i = 0; i < 4; i++) begin
            @(negedge conv_n);
            #1;
            chk((fall_t - last_fall_t) == 800, "R8 period ns", int'(fall_t - last_fall_t), 800);
        end
    endtask

    task automatic t_fast();
        int r0;
        r0 = rx_n;
        period = 16'd1;
        cyc(1500);
        chk(rx_n > r0 + 20, "R11 throughput words", rx_n - r0, 21);
        chk(n_over > 0, "R7 over-range seen", n_over, 1);
        chk(n_under > 0, "R7 under-range seen", n_under, 1);
    endtask

    task automatic t_backpressure();
        int f0;
        logic [13:0] c0;
        ready = 1'b0;
        cyc(200);
        f0 = n_falls; c0 = code;
        chk(valid === 1'b1, "R9 word waiting", int'(valid), 1);
        cyc(200);
        chk(n_falls == f0, "R9 no launch while full", n_falls, f0);
        chk(valid === 1'b1 && code == c0, "R9 word held", int'(code), int'(c0));
        ready = 1'b1;
        cyc(200);
        chk(n_falls > f0, "R9 resumes", n_falls, f0 + 1);
        free_run = 1'b0;
        cyc(100);
    endtask

    task automatic t_timeout();
        int e0, r0;
        alive = 0;
        e0 = err_n;
        pulse_req();
        cyc(150);
        chk(err_n == e0 + 1, "R10 timeout pulse", err_n - e0, 1);
        alive = 1;
        r0 = rx_n;
        pulse_req();
        cyc(100);
        chk(rx_n == r0, "R10 capture after fault discarded", rx_n - r0, 0);
        expect_first = 1; first_idx_exp = n_falls - 1;
        pulse_req();
        cyc(100);
        chk(rx_n == r0 + 1, "R10 recovery word", rx_n - r0, 1);
    endtask

    task automatic t_enable();
        int r0;
        en = 1'b0;
        cyc(50);
        r0 = rx_n;
        expect_first = 1; first_idx_exp = n_falls;
        period = 16'd80; free_run = 1'b1;
        en = 1'b1;
        cyc(400);
        chk(rx_n >= r0 + 3, "R5 words after enable", rx_n - r0, 3);
        chk(expect_first == 0, "R5 discard after enable", int'(expect_first), 0);
        en = 1'b0; free_run = 1'b0;
        cyc(100);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_single();
        t_period();
        t_fast();
        t_backpressure();
        t_timeout();
        t_enable();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule